// File: doc/BRIEF.md
# Offset-Translating SPI Flash Read Bridge

This block lets a processor read a serial SPI flash as if it were a plain ROM. A read request on a valid/ready port carries a 32-bit bus address. The block adds a constant offset to that address and keeps the low 24 bits of the sum. It opens a SPI transaction, sends the read command with that flash address, and shifts in four bytes. It then releases chip select and returns the bytes as one 32-bit word. The request stays unanswered for the whole serial transfer, so the bus sees wait states rather than a split.

A second, byte-wide port gives software direct access to the SPI wires, one byte per handshake, for identification, erase or programming. This path never applies the offset. Software supplies complete flash addresses inside the bytes it sends. Chip select stays low across a sequence of raw bytes until software marks a byte as the last one.

The serial clock is the system clock divided by one of two parameter divisors, chosen by a select input.

Top module: `sflash_rom_bridge`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `rd_ready` and `raw_ready` are 0.
- R2: A memory read sends command byte 0x03 and then the 24-bit flash address, MSB first. That address is (`rd_addr` + `OFFSET`) modulo 2^24, with a default `OFFSET` of 0x50000, so bus address 0 reads flash location 0x50000.
- R3: The four bytes received are packed big-endian. The first byte becomes `rd_data[31:24]` and the fourth becomes `rd_data[7:0]`.
- R4: `rd_ready` is a one-cycle pulse. It is raised only after all 64 serial bits have been transferred and in the same cycle `spi_cs_n` returns to 1. While the transfer runs the request is held with wait states.
- R5: Each half period of `spi_sck` lasts `DIV_MAIN` system cycles when `clk_sel` is 0 and `DIV_ALT` cycles when `clk_sel` is 1. The defaults are 2 and 7.
- R6: A flash that returns all-ones bytes yields `rd_data` = 0xFFFFFFFF, unchanged.
- R7: Each raw handshake shifts out `raw_tx` MSB first and returns the byte received in `raw_rx` with a one-cycle `raw_ready`. Chip select stays low across raw bytes until a byte sent with `raw_last` = 1 completes. No offset is applied on this path.
- R8: A memory read requested while a raw sequence holds chip select low is stalled until that sequence ends. It then runs normally.
- R9: When a memory read and a raw byte are both requested in the same idle cycle, the memory read is served first and the raw byte after it.
- R10: SPI mode 0: `spi_sck` is low whenever chip select is inactive, and `spi_mosi` changes only while `spi_sck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | Memory read request, held until `rd_ready` |
| rd_addr | input | 32 | Bus byte address of the read |
| rd_ready | output | 1 | One-cycle pulse: `rd_data` is valid |
| rd_data | output | 32 | Word read from the flash |
| raw_valid | input | 1 | Raw byte request, held until `raw_ready` |
| raw_tx | input | 8 | Byte to send on the raw path |
| raw_last | input | 1 | Release chip select after this raw byte |
| raw_ready | output | 1 | One-cycle pulse: raw byte done |
| raw_rx | output | 8 | Byte received during the raw transfer |
| clk_sel | input | 1 | 0 selects `DIV_MAIN`, 1 selects `DIV_ALT` |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A memory read and a raw byte request compete for the single serial engine. The bench raises both requests on the same falling clock edge while the bridge is idle. It records the cycle in which each ready pulse appears, and passes only if the read answer, with the correct data, comes before the raw answer. A related case opens a raw sequence first, then holds a read request for hundreds of cycles. Throughout that wait the bench expects no `rd_ready` and a chip select that stays low, and it expects the read to complete once the last raw byte closes the sequence.

// File: rtl/sfb_pkg.sv
// Shared definitions for the SPI flash read bridge.
// Assumes one serial engine shared by the memory path and the raw path.
package sfb_pkg;
    localparam logic [7:0] CMD_READ   = 8'h03;
    localparam int         FL_ADDR_W  = 24;
    localparam int         XFER_BYTES = 8;   // command, 3 address bytes, 4 data bytes

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // chip select high, nothing running
        ST_MEM  = 2'd1,   // memory-window read sequence
        ST_RAW  = 2'd2,   // one raw byte being shifted
        ST_HOLD = 2'd3    // raw sequence open, chip select held low
    } brg_state_t;
endpackage

// File: rtl/sfb_clkdiv.sv
// Tick generator for the serial clock.
// Emits a one-cycle tick every DIV_MAIN or DIV_ALT cycles while run is high.
// Each tick marks one SCK half period. Assumes both divisors are at least 2.
module sfb_clkdiv #(
    parameter int DIV_MAIN = 2,
    parameter int DIV_ALT  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic alt_sel,
    output logic tick
);
    localparam int DMAX = (DIV_MAIN > DIV_ALT) ? DIV_MAIN : DIV_ALT;
    localparam int CW   = $clog2(DMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Pick the terminal count for the active divisor.
    always_comb lim = alt_sel ? CW'(DIV_ALT - 1) : CW'(DIV_MAIN - 1);

    // Count system cycles and pulse once per half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // Ticks are never back to back, so each half period is at least two cycles.
    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sfb_shifter.sv
// Mode-0 byte shifter.
// On start it sends tx_byte MSB first while sampling miso on each rising SCK edge,
// then pulses done with the received byte. Assumes start is only given while idle.
module sfb_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte
);
    logic [7:0] sh;
    logic [2:0] bitn;

    // Load, then alternate rising (sample) and falling (shift) edges on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            bitn    <= '0;
            sck     <= 1'b0;
            mosi    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh   <= tx_byte;
                mosi <= tx_byte[7];
                bitn <= '0;
                sck  <= 1'b0;
                busy <= 1'b1;
            end else if (busy && tick) begin
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        sh   <= {sh[6:0], 1'b0};
                        mosi <= sh[6];
                        bitn <= bitn + 1'b1;
                    end
                end
            end
        end
    end

    // The serial clock rests low whenever no byte is in flight.
    assert_sck_rest_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
endmodule

// File: rtl/sflash_rom_bridge.sv
// SPI flash read bridge.
// Memory-window reads add OFFSET and fetch one big-endian word with command 0x03.
// Raw byte requests drive the bus without translation. One engine serves both;
// an open raw sequence blocks reads, and on a tie an idle read wins.
// Assumes requesters hold valid until their ready pulse.
module sflash_rom_bridge #(
    parameter logic [31:0] OFFSET   = 32'h0005_0000,
    parameter int          DIV_MAIN = 2,
    parameter int          DIV_ALT  = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_valid,
    input  logic [31:0] rd_addr,
    output logic        rd_ready,
    output logic [31:0] rd_data,
    input  logic        raw_valid,
    input  logic [7:0]  raw_tx,
    input  logic        raw_last,
    output logic        raw_ready,
    output logic [7:0]  raw_rx,
    input  logic        clk_sel,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    import sfb_pkg::*;

    localparam int IW = $clog2(XFER_BYTES);

    brg_state_t           st;
    logic [IW-1:0]        idx;
    logic [FL_ADDR_W-1:0] fl_addr;
    logic [23:0]          acc;
    logic                 last_q;
    logic                 sh_start;
    logic [7:0]           sh_tx;
    logic [7:0]           next_tx;
    logic [31:0]          sum;
    logic                 tick, busy, done;
    logic [7:0]           rx;

    sfb_clkdiv #(.DIV_MAIN(DIV_MAIN), .DIV_ALT(DIV_ALT)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .alt_sel(clk_sel), .tick(tick)
    );

    sfb_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .tick(tick),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(busy),
        .done(done), .rx_byte(rx)
    );

    // Translate the bus address into the flash window.
    always_comb sum = rd_addr + OFFSET;

    // Choose the byte that follows the one just finished in a memory read.
    always_comb begin
        case (idx)
            IW'(0):  next_tx = fl_addr[23:16];
            IW'(1):  next_tx = fl_addr[15:8];
            IW'(2):  next_tx = fl_addr[7:0];
            default: next_tx = 8'h00;
        endcase
    end

    // Sequence memory reads and raw bytes over the shared engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            idx       <= '0;
            fl_addr   <= '0;
            acc       <= '0;
            last_q    <= 1'b0;
            sh_start  <= 1'b0;
            sh_tx     <= '0;
            spi_cs_n  <= 1'b1;
            rd_ready  <= 1'b0;
            rd_data   <= '0;
            raw_ready <= 1'b0;
            raw_rx    <= '0;
        end else begin
            sh_start  <= 1'b0;
            rd_ready  <= 1'b0;
            raw_ready <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (rd_valid) begin
                        fl_addr  <= sum[FL_ADDR_W-1:0];
                        spi_cs_n <= 1'b0;
                        sh_tx    <= CMD_READ;
                        sh_start <= 1'b1;
                        idx      <= '0;
                        st       <= ST_MEM;
                    end else if (raw_valid) begin
                        spi_cs_n <= 1'b0;
                        sh_tx    <= raw_tx;
                        sh_start <= 1'b1;
                        last_q   <= raw_last;
                        st       <= ST_RAW;
                    end
                end
                ST_HOLD: begin
                    if (raw_valid) begin
                        sh_tx    <= raw_tx;
                        sh_start <= 1'b1;
                        last_q   <= raw_last;
                        st       <= ST_RAW;
                    end
                end
                ST_RAW: begin
                    if (done) begin
                        raw_rx    <= rx;
                        raw_ready <= 1'b1;
                        if (last_q) begin
                            spi_cs_n <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            st <= ST_HOLD;
                        end
                    end
                end
                ST_MEM: begin
                    if (done) begin
                        acc <= {acc[15:0], rx};
                        if (idx == IW'(XFER_BYTES - 1)) begin
                            rd_data  <= {acc, rx};
                            rd_ready <= 1'b1;
                            spi_cs_n <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            idx      <= idx + 1'b1;
                            sh_tx    <= next_tx;
                            sh_start <= 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Mode 0: clock low while deselected.
    assert_sck_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    // Mode 0: data only moves while the clock is low.
    assert_mosi_setup_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> !spi_sck);
    // Read answer coincides with chip select release and lasts one cycle.
    assert_ready_after_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (spi_cs_n && !busy));
    assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);
    // An open raw sequence keeps memory reads waiting.
    assert_stall_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD) |-> (!rd_ready && !spi_cs_n));
    // The two answers never share a cycle.
    assert_one_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ready && raw_ready));
endmodule

// File: tb/sflash_rom_bridge_test.sv
module sflash_rom_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        rd_ready;
    logic [31:0] rd_data;
    logic        raw_valid = 1'b0;
    logic [7:0]  raw_tx = '0;
    logic        raw_last = 1'b0;
    logic        raw_ready;
    logic [7:0]  raw_rx;
    logic        clk_sel = 1'b0;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    sflash_rom_bridge uut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .raw_valid(raw_valid),
        .raw_tx(raw_tx), .raw_last(raw_last), .raw_ready(raw_ready),
        .raw_rx(raw_rx), .clk_sel(clk_sel), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;

    // ---------------- flash model (mode 0, read command) ----------------
    function automatic logic [7:0] fbyte(input logic [23:0] a);
        if (a >= 24'h060000 && a < 24'h070000) return 8'hFF;  // erased region
        return a[7:0] * 8'd7 + a[15:8] + {4'h0, a[19:16]} * 8'd3 + 8'h11;
    endfunction

    function automatic logic [31:0] exp_word(input logic [23:0] a);
        return {fbyte(a), fbyte(a + 24'd1), fbyte(a + 24'd2), fbyte(a + 24'd3)};
    endfunction

    int          m_bits = 0;
    logic [31:0] m_hdr = '0;
    logic [7:0]  m_cmd = '0;
    logic [23:0] m_addr = '0;

    always @(negedge spi_cs_n) m_bits = 0;

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (m_bits < 32) m_hdr = {m_hdr[30:0], spi_mosi};
            m_bits = m_bits + 1;
            if (m_bits == 32) begin
                m_cmd  = m_hdr[31:24];
                m_addr = m_hdr[23:0];
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && m_bits >= 32) begin
            logic [7:0] b;
            b = fbyte(m_addr + 24'((m_bits - 32) / 8));
            spi_miso = b[7 - ((m_bits - 32) % 8)];
        end
    end

    // ---------------- SCK period monitor ----------------
    int cyc = 0;
    int last_rise = 0;
    int min_per = 100000;
    always @(posedge clk) cyc = cyc + 1;
    always @(posedge spi_sck) begin
        if (cyc - last_rise < min_per) min_per = cyc - last_rise;
        last_rise = cyc;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [31:0] a, output logic [31:0] d, output int waitc);
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr  = a;
        waitc    = 0;
        do begin
            @(negedge clk);
            waitc++;
        end while (!rd_ready);
        d = rd_data;
        rd_valid = 1'b0;
    endtask

    task automatic raw_xfer(input logic [7:0] tx, input bit last, output logic [7:0] rx);
        @(negedge clk);
        raw_valid = 1'b1;
        raw_tx    = tx;
        raw_last  = last;
        do @(negedge clk); while (!raw_ready);
        rx = raw_rx;
        raw_valid = 1'b0;
        raw_last  = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(spi_cs_n == 1'b1, "R1 cs_n after reset", 32'(spi_cs_n), 32'd1);
        chk(spi_sck == 1'b0, "R1 sck after reset", 32'(spi_sck), 32'd0);
        chk(rd_ready == 1'b0 && raw_ready == 1'b0, "R1 ready after reset",
            {30'd0, rd_ready, raw_ready}, 32'd0);
    endtask

    task automatic t_first_fetch();
        logic [31:0] d;
        int w;
        min_per = 100000;
        do_read(32'h0, d, w);
        chk(m_cmd == 8'h03, "R2 read command byte", 32'(m_cmd), 32'h03);
        chk(m_addr == 24'h050000, "R2 offset on address 0", 32'(m_addr), 32'h050000);
        chk(d == exp_word(24'h050000), "R3 word packing at 0x50000", d, exp_word(24'h050000));
        chk(w >= 256, "R4 wait states cover 64 bits", 32'(w), 32'd256);
        chk(spi_cs_n == 1'b1, "R4 cs released at answer", 32'(spi_cs_n), 32'd1);
        chk(min_per == 4, "R5 main divisor period", 32'(min_per), 32'd4);
        @(negedge clk);
        chk(rd_ready == 1'b0, "R4 ready is one cycle", 32'(rd_ready), 32'd0);
    endtask

    task automatic t_other_addr();
        logic [31:0] d;
        int w;
        do_read(32'h0000_0123, d, w);
        chk(m_addr == 24'h050123, "R2 offset on 0x123", 32'(m_addr), 32'h050123);
        chk(d == exp_word(24'h050123), "R3 word packing at 0x50123", d, exp_word(24'h050123));
    endtask

    task automatic t_erased();
        logic [31:0] d;
        int w;
        do_read(32'h0001_0008, d, w);
        chk(d == 32'hFFFF_FFFF, "R6 erased data passed through", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_alt_div();
        logic [31:0] d;
        int w;
        clk_sel = 1'b1;
        min_per = 100000;
        do_read(32'h0000_0040, d, w);
        chk(min_per == 14, "R5 alternate divisor period", 32'(min_per), 32'd14);
        chk(d == exp_word(24'h050040), "R5 data with alternate divisor", d, exp_word(24'h050040));
        clk_sel = 1'b0;
    endtask

    task automatic t_raw();
        logic [7:0] rx;
        logic [7:0] got [4];
        raw_xfer(8'h03, 1'b0, rx);
        chk(spi_cs_n == 1'b0, "R7 cs held between raw bytes", 32'(spi_cs_n), 32'd0);
        raw_xfer(8'h00, 1'b0, rx);
        raw_xfer(8'h00, 1'b0, rx);
        raw_xfer(8'h10, 1'b0, rx);
        for (int i = 0; i < 4; i++) raw_xfer(8'h00, (i == 3), got[i]);
        chk(m_addr == 24'h000010, "R7 raw address not offset", 32'(m_addr), 32'h000010);
        chk({got[0], got[1], got[2], got[3]} == exp_word(24'h000010), "R7 raw bytes received",
            {got[0], got[1], got[2], got[3]}, exp_word(24'h000010));
        chk(spi_cs_n == 1'b1, "R7 cs released after last byte", 32'(spi_cs_n), 32'd1);
    endtask

    task automatic t_stall();
        logic [7:0] rx;
        bit seen = 1'b0;
        bit cs_ok = 1'b1;
        raw_xfer(8'h05, 1'b0, rx);
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr  = 32'h0000_0004;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (rd_ready) seen = 1'b1;
            if (spi_cs_n) cs_ok = 1'b0;
        end
        chk(!seen, "R8 read stalled during raw sequence", 32'(seen), 32'd0);
        chk(cs_ok, "R8 raw sequence keeps cs low", 32'(cs_ok), 32'd1);
        raw_xfer(8'h00, 1'b1, rx);
        do @(negedge clk); while (!rd_ready);
        chk(rd_data == exp_word(24'h050004), "R8 stalled read completes", rd_data,
            exp_word(24'h050004));
        rd_valid = 1'b0;
    endtask

    task automatic t_same_cycle();
        int c = 0;
        int t_rd = -1;
        int t_raw = -1;
        logic [31:0] d = '0;
        @(negedge clk);
        rd_valid  = 1'b1;
        rd_addr   = 32'h0000_0008;
        raw_valid = 1'b1;
        raw_tx    = 8'h9F;
        raw_last  = 1'b1;
        while (t_rd < 0 || t_raw < 0) begin
            @(negedge clk);
            c++;
            if (rd_ready) begin t_rd = c; d = rd_data; rd_valid = 1'b0; end
            if (raw_ready) begin t_raw = c; raw_valid = 1'b0; raw_last = 1'b0; end
        end
        chk(t_rd < t_raw, "R9 memory read served first", 32'(t_rd), 32'(t_raw));
        chk(d == exp_word(24'h050008), "R9 read data on tie", d, exp_word(24'h050008));
        chk(spi_sck == 1'b0 && spi_cs_n == 1'b1, "R10 bus idles with sck low",
            {30'd0, spi_sck, spi_cs_n}, 32'd1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_first_fetch();
        t_other_addr();
        t_erased();
        t_alt_div();
        t_raw();
        t_stall();
        t_same_cycle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule